// File: doc/BRIEF.md
# Three-Sample Vote Debouncer

This block cleans up a group of slow discrete inputs such as switches or contacts that bounce. All channels are filtered in parallel, one bit per channel. An external strobe sets the sampling instants. A channel's clean output takes a new level only after the input has shown that level at three strobes in a row.

At each strobe the block forms a window for every channel from three samples: the raw bit arriving now, the sample taken at the previous strobe, and the one taken at the strobe before that. A window of all ones drives the output high. A window of all zeros drives it low. Any mixed window leaves the output where it is. As a result, one high sample anywhere in the window keeps a high output high. The two stored samples then shift along by one place. The whole vector is updated with bitwise logic in the same clock, so no channel needs its own counter.

Top module: `deb3_filter`

## Requirements
- R1: Each strobe moves the stored samples along by one place: the raw input becomes the newest stored sample and the newest becomes the oldest. The number of idle clocks between strobes has no effect on this.
- R2: An output bit goes from 0 to 1 only at a strobe where the raw bit and both stored samples of that channel are 1.
- R3: An output bit goes from 1 to 0 only at a strobe where the raw bit and both stored samples of that channel are 0.
- R4: In a clock without a strobe, the output and the stored samples keep their values whatever the raw input does.
- R5: While the synchronous active-low reset is low, the output and both stored samples are held at zero.
- R6: A window that mixes ones and zeros leaves the output bit unchanged. A high output therefore stays high while at least one of its three samples is 1.
- R7: Every bit position is an independent channel. Its output depends only on the same bit position of the raw input.
- R8: The output is registered. A strobe seen at a clock edge updates the output at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | Sample strobe, one clock wide per sampling instant |
| raw_in | input | WIDTH | Raw channel levels |
| clean_out | output | WIDTH | Debounced channel levels |

## Verification
The hardest case to reach is a high output that must survive a long bounce. This needs windows that always hold at least one 1 but never three, followed by exactly three zeros in a row. A second hard case is a rise that has to span idle gaps between strobes. The directed stimulus walks each of these sequences on purpose, with idle clocks placed between the strobes. It then gives every channel of a byte a different pattern, so that rises, falls and holds happen in the same strobe. A long run of random strobes and levels follows, including a mid-run reset. A behavioural sample-counting model checks the output on every clock.

// File: rtl/deb3_pkg.sv
package deb3_pkg;
  // Number of stored samples per channel; the raw bit supplies the third.
  localparam int unsigned HIST_DEPTH = 2;

  // One channel: all ones sets, all zeros clears, a mixed window holds.
  function automatic logic settle_bit(input logic newest, input logic prev,
                                      input logic oldest, input logic held);
    return (newest & prev & oldest) | (held & (newest | prev | oldest));
  endfunction
endpackage

// File: rtl/deb3_history.sv
module deb3_history #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic [WIDTH-1:0]             din,
  output logic [DEPTH-1:0][WIDTH-1:0]  taps
);
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic [WIDTH-1:0] stage_in;
      if (s == 0) begin : g_head
        assign stage_in = din;
      end else begin : g_tail
        assign stage_in = taps[s-1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n)        taps[s] <= '0;
        else if (shift_en) taps[s] <= stage_in;
      end
    end
  endgenerate
endmodule

// File: rtl/deb3_vote.sv
module deb3_vote #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] newest,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] oldest,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] next_level
);
  import deb3_pkg::*;
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_chan
      assign next_level[b] = settle_bit(newest[b], prev[b], oldest[b], held[b]);
    end
  endgenerate
endmodule

// File: rtl/deb3_filter.sv
module deb3_filter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] clean_out
);
  import deb3_pkg::*;
  localparam int unsigned DEPTH = HIST_DEPTH;

  logic [DEPTH-1:0][WIDTH-1:0] taps;
  logic [WIDTH-1:0]            hist_new;
  logic [WIDTH-1:0]            hist_old;
  logic [WIDTH-1:0]            vote_level;
  logic [WIDTH-1:0]            out_q;

  deb3_history #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sample_en),
    .din      (raw_in),
    .taps     (taps)
  );

  assign hist_new = taps[0];
  assign hist_old = taps[DEPTH-1];

  deb3_vote #(.WIDTH(WIDTH)) u_vote (
    .newest     (raw_in),
    .prev       (hist_new),
    .oldest     (hist_old),
    .held       (out_q),
    .next_level (vote_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         out_q <= '0;
    else if (sample_en) out_q <= vote_level;
  end

  assign clean_out = out_q;
endmodule

// File: rtl/deb3_filter_chk.sv
module deb3_filter_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic [WIDTH-1:0] raw_in,
  input logic [WIDTH-1:0] clean_out,
  input logic [WIDTH-1:0] hist_new,
  input logic [WIDTH-1:0] hist_old
);
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> (hist_new == $past(raw_in)) && (hist_old == $past(hist_new)));

  p_rise_all_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((clean_out & ~$past(clean_out)) &
      ~$past(raw_in & hist_new & hist_old & {WIDTH{sample_en}})) == '0);

  p_fall_all_zeros_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~clean_out & $past(clean_out)) &
      ($past(raw_in | hist_new | hist_old) | ~{WIDTH{$past(sample_en)}})) == '0);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(clean_out) && $stable(hist_new) && $stable(hist_old));
endmodule

bind deb3_filter deb3_filter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_en (sample_en),
  .raw_in    (raw_in),
  .clean_out (clean_out),
  .hist_new  (hist_new),
  .hist_old  (hist_old)
);

// File: tb/deb3_filter_tb.sv
module deb3_filter_tb;
  localparam int unsigned WIDTH  = 8;
  localparam time         CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sample_en = 1'b0;
  logic [WIDTH-1:0] raw_in = '0;
  logic [WIDTH-1:0] clean_out;

  int checks = 0;
  int errors = 0;

  // Behavioural reference: remembered samples and a per-channel count of ones.
  logic [WIDTH-1:0] m_recent, m_older, m_out, m_out_prev;

  deb3_filter #(.WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .raw_in(raw_in), .clean_out(clean_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    m_out_prev = m_out;
    if (!rst_n) begin
      m_recent = '0; m_older = '0; m_out = '0;
    end else if (sample_en) begin
      for (int b = 0; b < WIDTH; b++) begin
        int ones;
        ones = int'(raw_in[b]) + int'(m_recent[b]) + int'(m_older[b]);
        if (ones == 3)      m_out[b] = 1'b1;
        else if (ones == 0) m_out[b] = 1'b0;
      end
      m_older  = m_recent;
      m_recent = raw_in;
    end
  end

  task automatic check(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clean_out=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every clock: compare with the model; tag by what the model did.
  always @(negedge clk) begin
    if (rst_n) begin
      if ((m_out & ~m_out_prev) != '0)      check("R2 rise", clean_out, m_out);
      else if ((~m_out & m_out_prev) != '0) check("R3 fall", clean_out, m_out);
      else                                  check("R6 hold", clean_out, m_out);
    end
  end

  task automatic step(input logic [WIDTH-1:0] v, input logic en);
    @(negedge clk);
    raw_in = v; sample_en = en;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic idle(input int n, input logic [WIDTH-1:0] v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); raw_in = v; sample_en = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: clean_out=%h expected run to end", clean_out);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R5: reset holds zero even with strobes and all-ones input
    raw_in = '1; sample_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 reset", clean_out, '0);
    rst_n = 1'b1; sample_en = 1'b0;

    // R8 and R2: third strobe of ones rises at that edge
    step('1, 1'b1);
    step('1, 1'b1);
    check("R2 two samples only", clean_out, '0);
    @(negedge clk); raw_in = '1; sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    check("R8 same-edge update", clean_out, '1);

    // R6: bounce that always keeps a one in the window
    step(8'h00, 1'b1); step(8'h00, 1'b1); step(8'hFF, 1'b1);
    step(8'h00, 1'b1); step(8'h00, 1'b1);
    check("R6 single one holds", clean_out, '1);
    // R3: third zero in a row clears
    step(8'h00, 1'b1);
    check("R3 three zeros", clean_out, '0);

    // R4: no strobe, ones on input, nothing moves
    idle(6, '1);
    check("R4 idle output", clean_out, '0);
    step('1, 1'b1); step('1, 1'b1);
    check("R4 history untouched", clean_out, '0);

    // R1: strobes with gaps still count consecutively
    step('0, 1'b1); step('0, 1'b1); step('0, 1'b1);
    step('1, 1'b1); idle(3, '0);
    step('1, 1'b1); idle(5, '0);
    check("R1 gap no early rise", clean_out, '0);
    step('1, 1'b1);
    check("R1 gap rise", clean_out, '1);

    // R7: different pattern per channel
    step(8'h00, 1'b1); step(8'h00, 1'b1); step(8'h00, 1'b1);
    step(8'hA5, 1'b1); step(8'hA5, 1'b1); step(8'hA5, 1'b1);
    check("R7 set A5", clean_out, 8'hA5);
    step(8'h5A, 1'b1);
    check("R7 mixed hold", clean_out, 8'hA5);
    step(8'h5A, 1'b1); step(8'h5A, 1'b1);
    check("R7 swap 5A", clean_out, 8'h5A);

    // Random run with a reset in the middle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      raw_in = (($urandom % 4) == 0) ? WIDTH'($urandom) :
               (($urandom % 2) == 0) ? '1 : '0;
      sample_en = ($urandom % 3) != 0;
      if (i == 1500) rst_n = 1'b0;
      if (i == 1502) rst_n = 1'b1;
    end
    @(negedge clk); sample_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R5 reset mid-run", clean_out, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule